// File: doc/BRIEF.md
# Shadow-Reload Timer PWM

This block is a single-channel pulse-width modulator driven by a timestamp counter that runs freely once started. Software reaches it through a small register port. Two register pairs hold the period and compare values:

- The active pair sets the waveform currently on the pin.
- The shadow pair holds the next waveform. It is copied into the active pair only when the running period ends, so a running waveform is never cut short.

Only a shadow register written since the last period end is copied. A value written straight into the active pair is therefore not overwritten by stale shadow contents.

A control register holds four fields:

- a counter run enable;
- a PWM-mode enable, which gates the pin (the pin stays low while it is clear);
- a polarity select, which decides whether the compare value measures the high or the low part of each period;
- a two-bit sync-select field, which is stored and read back but changes nothing.

A one-cycle event output marks the last cycle of each period.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped at 0, and both `pwm_out` and `prd_evt` are low.
- R2: Register offsets are:

  | Offset | Register |
  |---|---|
  | 0x00 | active period |
  | 0x04 | active compare |
  | 0x08 | shadow period |
  | 0x0C | shadow compare |
  | 0x10 | control |

  Control bits are: bit 0 run, bit 1 PWM mode, bit 2 inverse polarity, bits 5:4 sync select. Reads return the stored values. Control bits that are not implemented read as 0. The sync-select field has no effect on the waveform.
- R3: With run set and active period P (P ≥ 2), the counter steps 0,1,…,P-1 and then returns to 0. `prd_evt` is high exactly in the cycle the counter holds P-1. A period of 0 or 1 gives a one-cycle period, with `prd_evt` high in every cycle. With run clear the counter rests at 0 and `prd_evt` stays low.
- R4: With normal polarity and PWM mode on, `pwm_out` is high while the counter is below the active compare value C. C = 0 gives constant low, and C ≥ P gives constant high.
- R5: With inverse polarity and PWM mode on, `pwm_out` is the complement of the R4 waveform.
- R6: With PWM mode off, `pwm_out` is low whatever the counter, compare value or polarity.
- R7: A write to an active register changes `pwm_out` from the next cycle on.
- R8: A shadow write made while running leaves the current period unchanged. It is copied into the active register at the end of that period.
- R9: At a period end, a shadow register that has not been written since the previous period end is not copied. This means a value written directly to the active register survives.
- R10: A shadow write landing in the last cycle of a period is not taken at that period end. It stays pending and is copied at the following period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counts are in these cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | PWM pin |
| prd_evt | output | 1 | High in the last cycle of each period |

## Verification
Two things can fall in the same cycle: a register write and the period-end transfer from the shadow pair into the active pair. The bench provokes this by issuing a shadow-compare write in exactly the cycle where `prd_evt` is high. It then judges the result from the waveform. The period that follows must still use the old compare value, and only the period after that may use the new one. Separate runs check that a period end with nothing pending leaves directly written active values intact. They also check that writes made mid-period change nothing before the period end.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

   // byte offsets of the register map
   localparam int unsigned OFS_ACT_BASE = 32'h00;  // active period, active compare
   localparam int unsigned OFS_SHD_BASE = 32'h08;  // shadow period, shadow compare
   localparam int unsigned OFS_CTL      = 32'h10;
   localparam int unsigned LANE_STRIDE  = 4;
   localparam int unsigned NLANE        = 2;       // lane 0 period, lane 1 compare
   localparam int unsigned LANE_PRD     = 0;
   localparam int unsigned LANE_CMP     = 1;

   typedef struct packed {
      logic [1:0] sync_sel;
      logic       inv;
      logic       mode;
      logic       run;
   } pwm_ctl_t;

   function automatic pwm_ctl_t ctl_unpack(input logic [15:0] w);
      pwm_ctl_t c;
      c.run      = w[0];
      c.mode     = w[1];
      c.inv      = w[2];
      c.sync_sel = w[5:4];
      return c;
   endfunction

   function automatic logic [15:0] ctl_pack(input pwm_ctl_t c);
      return {10'd0, c.sync_sel, 1'b0, c.inv, c.mode, c.run};
   endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] prd,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic last;

   // period of 0 or 1 collapses to a single-cycle period
   assign last = (prd <= ONE) || (cnt >= prd - ONE);
   assign wrap = run && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || last)  cnt <= '0;
      else                    cnt <= cnt + ONE;
   end

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0)); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> (cnt == $past(cnt) + ONE)); // R3

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_shadow_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              wrap,
   output logic [CNT_W-1:0]  act_prd,
   output logic [CNT_W-1:0]  act_cmp,
   output pwm_ctl_t          ctl,
   output logic [REG_W-1:0]  rdata
);
   logic [CNT_W-1:0] act [NLANE];
   logic [CNT_W-1:0] shd [NLANE];
   logic [NLANE-1:0] pend;
   logic [NLANE-1:0] act_hit;
   logic [NLANE-1:0] shd_hit;
   logic             ctl_hit;

   assign ctl_hit = wr && (addr == ADDR_W'(OFS_CTL));

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int unsigned ACT_OFS = OFS_ACT_BASE + LANE_STRIDE * g;
      localparam int unsigned SHD_OFS = OFS_SHD_BASE + LANE_STRIDE * g;

      assign act_hit[g] = wr && (addr == ADDR_W'(ACT_OFS));
      assign shd_hit[g] = wr && (addr == ADDR_W'(SHD_OFS));

      // later statements win: a direct active write beats the transfer,
      // a shadow write in the boundary cycle stays pending
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act[g]  <= '0;
            shd[g]  <= '0;
            pend[g] <= 1'b0;
         end else begin
            if (wrap) begin
               if (pend[g]) act[g] <= shd[g];
               pend[g] <= 1'b0;
            end
            if (act_hit[g]) act[g] <= wdata[CNT_W-1:0];
            if (shd_hit[g]) begin
               shd[g]  <= wdata[CNT_W-1:0];
               pend[g] <= 1'b1;
            end
         end
      end

      AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (wrap && pend[g] && !act_hit[g]) |=> (act[g] == $past(shd[g]))); // R8
      AST_NO_STALE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (wrap && !pend[g] && !act_hit[g]) |=> $stable(act[g])); // R9
      AST_LATE_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (wrap && shd_hit[g]) |=> pend[g]); // R10
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl <= '0;
      else if (ctl_hit) ctl <= ctl_unpack(wdata[15:0]);
   end

   assign act_prd = act[LANE_PRD];
   assign act_cmp = act[LANE_CMP];

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NLANE; i++) begin
         if (addr == ADDR_W'(OFS_ACT_BASE + LANE_STRIDE * i)) rdata = REG_W'(act[i]);
         if (addr == ADDR_W'(OFS_SHD_BASE + LANE_STRIDE * i)) rdata = REG_W'(shd[i]);
      end
      if (addr == ADDR_W'(OFS_CTL)) rdata = REG_W'(ctl_pack(ctl));
   end

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
   parameter int unsigned CNT_W   = 32,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             mode,
   input  logic             inv,
   output logic             pwm
);
   logic level;

   assign level = mode && ((cnt < cmp) ^ inv);

   if (OUT_REG) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm <= 1'b0;
         else        pwm <= level;
      end
      AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!mode) |-> !pwm); // R6
   end else begin : g_comb
      assign pwm = level;
      AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !mode |-> !pwm); // R6
   end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
   import pwm_shadow_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned REG_W   = 32,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              pwm_out,
   output logic              prd_evt
);
   localparam int unsigned MIN_ADDR_W = $clog2(OFS_CTL + 1);

   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and REG_W");
   end
   if (REG_W < 16) begin : g_bad_reg_w
      $error("REG_W must hold the 16-bit control register");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   logic [CNT_W-1:0] act_prd;
   logic [CNT_W-1:0] act_cmp;
   logic [CNT_W-1:0] cnt;
   logic             wrap;
   pwm_ctl_t         ctl;

   pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .wrap    (wrap),
      .act_prd (act_prd),
      .act_cmp (act_cmp),
      .ctl     (ctl),
      .rdata   (reg_rdata)
   );

   pwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctl.run),
      .prd   (act_prd),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   pwm_outstage #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .cmp   (act_cmp),
      .mode  (ctl.mode),
      .inv   (ctl.inv),
      .pwm   (pwm_out)
   );

   assign prd_evt = wrap;

   AST_EVT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      prd_evt |-> ctl.run); // R3
   AST_STOP_RESTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.run |=> (cnt == '0)); // R3

endmodule

// File: tb/tb_pwm_shadow_timer.sv
`timescale 1ns/1ps
module tb_pwm_shadow_timer;

   localparam logic [7:0] A_APRD = 8'h00, A_ACMP = 8'h04;
   localparam logic [7:0] A_SPRD = 8'h08, A_SCMP = 8'h0C, A_CTL = 8'h10;
   localparam logic [31:0] C_RUN = 32'h1, C_MODE = 32'h2, C_INV = 32'h4, C_SYNC = 32'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pwm_out;
   logic        prd_evt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_shadow_timer dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .prd_evt(prd_evt)
   );

   // one cycle: optionally check outputs at the falling edge, then drive the port
   task automatic cyc(input bit chk, input bit eo, input bit ee, input bit w,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
      @(negedge clk);
      if (chk) begin
         n_chk++;
         if (pwm_out !== eo || prd_evt !== ee) begin
            n_fail++;
            $display("FAIL %s: pwm_out=%b prd_evt=%b expected %b %b", tag, pwm_out, prd_evt, eo, ee);
         end
      end
      reg_wr = w; reg_addr = a; reg_wdata = d;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b0, 1'b0, 1'b0, 1'b1, a, d, "");
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      #0.5;
      n_chk++;
      if (reg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s: rdata@%h=%h expected %h", tag, a, reg_rdata, exp);
      end
   endtask

   // stop, load active pair, then write control; counter is 0 at the next sample
   task automatic cfg(input int p, input int c, input logic [31:0] ctl);
      wr(A_CTL, 32'h0);
      wr(A_APRD, 32'(p));
      wr(A_ACMP, 32'(c));
      wr(A_CTL, ctl);
   endtask

   // samples counter positions i0..i0+n-1 of a period P waveform
   task automatic run_pat(input int i0, input int n, input int p, input int c,
                          input bit mode, input bit inv, input int wr_at,
                          input logic [7:0] a, input logic [31:0] d, input string tag);
      for (int i = i0; i < i0 + n; i++) begin
         int ph = i % p;
         bit eo = mode && ((ph < c) ^ inv);
         bit ee = (ph == p - 1);
         cyc(1'b1, eo, ee, (i == wr_at), a, d, tag);
      end
   endtask

   task automatic t_reset();
      rd_chk(A_APRD, 0, "R1 active period");
      rd_chk(A_ACMP, 0, "R1 active compare");
      rd_chk(A_SPRD, 0, "R1 shadow period");
      rd_chk(A_SCMP, 0, "R1 shadow compare");
      rd_chk(A_CTL,  0, "R1 control");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h0, 0, "R1 outputs");
   endtask

   task automatic t_readback();
      wr(A_APRD, 32'h1234_5678);
      rd_chk(A_APRD, 32'h1234_5678, "R2 active period");
      wr(A_ACMP, 32'h0BAD_F00D);
      rd_chk(A_ACMP, 32'h0BAD_F00D, "R2 active compare");
      wr(A_CTL, 32'hFFFF);
      rd_chk(A_CTL, 32'h0037, "R2 control mask");
      wr(A_CTL, 32'h0);
   endtask

   task automatic t_normal();
      cfg(10, 3, C_RUN | C_MODE);
      run_pat(0, 20, 10, 3, 1, 0, -1, 0, 0, "R3/R4 normal p10 c3");
   endtask

   task automatic t_inverse();
      cfg(8, 3, C_RUN | C_MODE | C_INV);
      run_pat(0, 16, 8, 3, 1, 1, -1, 0, 0, "R5 inverse p8 c3");
   endtask

   task automatic t_edges();
      cfg(5, 0, C_RUN | C_MODE);
      run_pat(0, 10, 5, 0, 1, 0, -1, 0, 0, "R4 compare 0");
      cfg(5, 5, C_RUN | C_MODE);
      run_pat(0, 10, 5, 5, 1, 0, -1, 0, 0, "R4 compare equals period");
      cfg(5, 9, C_RUN | C_MODE);
      run_pat(0, 10, 5, 9, 1, 0, -1, 0, 0, "R4 compare above period");
      cfg(1, 1, C_RUN | C_MODE);
      run_pat(0, 6, 1, 1, 1, 0, -1, 0, 0, "R3 period 1 c1");
      cfg(1, 0, C_RUN | C_MODE);
      run_pat(0, 4, 1, 0, 1, 0, -1, 0, 0, "R3 period 1 c0");
   endtask

   task automatic t_mode_off();
      cfg(6, 4, C_RUN);
      run_pat(0, 12, 6, 4, 0, 0, -1, 0, 0, "R6 mode off normal");
      cfg(6, 4, C_RUN | C_INV);
      run_pat(0, 12, 6, 4, 0, 1, -1, 0, 0, "R6 mode off inverse");
   endtask

   task automatic t_sync();
      cfg(10, 3, C_RUN | C_MODE | C_SYNC);
      run_pat(0, 20, 10, 3, 1, 0, -1, 0, 0, "R2 sync field no effect");
      wr(A_CTL, C_SYNC);
      rd_chk(A_CTL, 32'h30, "R2 sync readback");
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h0, 0, "R3 stopped no event");
   endtask

   task automatic t_active();
      wr(A_CTL, C_MODE);
      wr(A_ACMP, 0);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, A_ACMP, 32'd4, "R7 compare 0 low");
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h0, 0, "R7 compare 4 high next cycle");
   endtask

   task automatic t_shadow();
      cfg(10, 3, C_RUN | C_MODE);
      run_pat(0, 5, 10, 3, 1, 0, 4, A_SPRD, 32'd6, "R8 old period before boundary");
      run_pat(5, 5, 10, 3, 1, 0, 5, A_SCMP, 32'd5, "R8 old period undisturbed");
      run_pat(0, 12, 6, 5, 1, 0, -1, 0, 0, "R8 new period after boundary");
      wr(A_CTL, 0);
      rd_chk(A_APRD, 6, "R8 active period loaded");
      rd_chk(A_ACMP, 5, "R8 active compare loaded");
      rd_chk(A_SPRD, 6, "R2 shadow period readback");
      rd_chk(A_SCMP, 5, "R2 shadow compare readback");
   endtask

   task automatic t_pending();
      cfg(10, 3, C_RUN | C_MODE);
      run_pat(0, 20, 10, 3, 1, 0, -1, 0, 0, "R9 no stale shadow copy");
      run_pat(0, 10, 10, 3, 1, 0, 0, A_SCMP, 32'd7, "R9 compare-only write mid period");
      run_pat(0, 10, 10, 7, 1, 0, -1, 0, 0, "R9 only compare transferred");
   endtask

   task automatic t_late();
      run_pat(0, 10, 10, 7, 1, 0, 9, A_SCMP, 32'd2, "R10 write in boundary cycle");
      run_pat(0, 10, 10, 7, 1, 0, -1, 0, 0, "R10 not taken at that boundary");
      run_pat(0, 10, 10, 2, 1, 0, -1, 0, 0, "R10 taken at following boundary");
      wr(A_CTL, 0);
      rd_chk(A_ACMP, 2, "R10 active compare");
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_readback();
      t_normal();
      t_inverse();
      t_edges();
      t_mode_off();
      t_sync();
      t_active();
      t_shadow();
      t_pending();
      t_late();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule